// File: doc/BRIEF.md
# Bi-Endian Load/Store Lane Steering

This block sits between the load/store port of a 32-bit processor core and a 32-bit byte-addressed memory bus. On a store it places the register data on the bus byte lanes and raises the matching byte enables. On a load it collects the addressed bytes from the bus read data and returns them as a 32-bit register value. Byte and word results are zero-extended or sign-extended. Byte, word and longword sizes are handled. Word and longword requests must be naturally aligned. A misaligned request is reported on an error output and moves nothing.

Byte ordering is chosen once. While the active-low power-on reset is held, a strap input is sampled on each clock edge, and the last sampled value is kept until the next power-on reset. Accesses whose address falls inside a parameterised device-register window always use big-endian lane mapping, whatever the kept mode is. The datapath from request to bus lanes and load value is combinational. The only state is the one-bit mode flag.

Top module: `endian_lane_steer`

## Requirements
- R1: While `por_n` is low, each rising clock edge loads the mode flag from `endian_strap`. Strap 0 selects big-endian and strap 1 selects little-endian. While reset is held with no request, `bus_be`, `bus_we` and `req_error` are 0.
- R2: Once `por_n` is high, the mode flag keeps its value. Strap changes have no effect on lane mapping until the next power-on reset.
- R3: Bus byte lane k (`bus_wdata`/`bus_rdata` bits [8k+7:8k], `bus_be[k]`) carries the byte at address offset k, where k = `req_addr[1:0]`. In little-endian mode, a longword store to A puts register bits [7:0] at A and bits [31:24] at A+3. A word store puts bits [7:0] at the lower address and bits [15:8] at the next address.
- R4: In big-endian mode, a longword store to A puts register bits [31:24] at A and bits [7:0] at A+3. A word store puts bits [15:8] at the lower address and bits [7:0] at the next address.
- R5: `req_size` encodes 0 = byte, 1 = word, 2 = longword, and 3 is reserved. A byte access always moves register bits [7:0] to or from lane `req_addr[1:0]`, with exactly one enable set. Lanes that are not addressed read as zero on `bus_wdata`.
- R6: When (`req_addr` & WIN_MASK) == WIN_BASE, big-endian mapping is used even in little-endian mode. With the defaults, this is every address whose top byte is 0xFF.
- R7: A word access with `req_addr[0]`=1, a longword access with `req_addr[1:0]`≠0, or size 3 raises `req_error`. In that case all of `bus_be` are 0, `bus_we` is 0, `bus_wdata` is 0 and `load_data` is 0.
- R8: For loads, `req_signed`=1 copies bit 7 (byte) or bit 15 (word) into the upper bits of `load_data`. `req_signed`=0 fills the upper bits with zeros.
- R9: A load gathers its bytes from the bus lanes through the same mapping that a store of that size, address and effective ordering would use, including the window override. On a load `bus_be` shows the lanes that are read.
- R10: Every output follows the request inputs within the same clock cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset |
| endian_strap | input | 1 | Ordering strap, sampled only during reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 word, 2 longword, 3 reserved |
| req_signed | input | 1 | Sign-extend load result |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Register data to store |
| bus_rdata | input | 32 | Bus read lanes |
| bus_be | output | 4 | Byte lane enables |
| bus_we | output | 1 | Bus write strobe |
| bus_wdata | output | 32 | Bus write lanes |
| load_data | output | 32 | Extended load result |
| req_error | output | 1 | Misaligned or reserved-size request |

## Verification
Two functions can apply to the same request: the window override and the misalignment check. Both act together when a misaligned word or longword targets the device-register window while the kept mode is little-endian. The bench provokes this with both stores and loads. It expects the error to win, with no enables, no write and zeroed data. An aligned request to the same window under little-endian mode must then show big-endian lanes. The strap is also toggled after reset in the same stretch of traffic, and this must not change the mapping.

// File: rtl/els_pkg.sv
package els_pkg;

  localparam int LANES = 4;
  localparam int REG_W = 8 * LANES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef struct packed {
    logic       hit;
    logic [1:0] idx;
  } lane_src_t;

  // Which register byte a bus lane carries, if any, for a given access.
  function automatic lane_src_t lane_source(size_e sz, logic [1:0] off,
                                            logic big, logic [1:0] lane);
    lane_src_t r;
    r = '0;
    case (sz)
      SZ_LONG: begin
        r.hit = 1'b1;
        r.idx = big ? ~lane : lane;
      end
      SZ_WORD: begin
        r.hit = (lane[1] == off[1]);
        r.idx = {1'b0, big ? ~lane[0] : lane[0]};
      end
      SZ_BYTE: begin
        r.hit = (lane == off);
        r.idx = 2'd0;
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic misaligned(size_e sz, logic [1:0] off);
    case (sz)
      SZ_BYTE: return 1'b0;
      SZ_WORD: return off[0];
      SZ_LONG: return |off;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] extend(size_e sz, logic sgn,
                                              logic [REG_W-1:0] v);
    case (sz)
      SZ_BYTE: return {{(REG_W-8){sgn & v[7]}}, v[7:0]};
      SZ_WORD: return {{(REG_W-16){sgn & v[15]}}, v[15:0]};
      default: return v;
    endcase
  endfunction

endpackage

// File: rtl/els_mode_latch.sv
module els_mode_latch (
  input  logic clk,
  input  logic por_n,
  input  logic strap,
  output logic little_o
);
  logic little_q;

  always_ff @(posedge clk) begin
    if (!por_n) little_q <= strap;
  end

  assign little_o = little_q;

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!por_n)
    $past(por_n) |-> $stable(little_q));

endmodule

// File: rtl/els_region_decode.sv
module els_region_decode #(
  parameter int          ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = '1,
  parameter logic [ADDR_W-1:0] MASK = '1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  assign hit = ((addr & MASK) == (BASE & MASK));
endmodule

// File: rtl/els_store_steer.sv
module els_store_steer
  import els_pkg::*;
(
  input  size_e             sz,
  input  logic [1:0]        off,
  input  logic              big,
  input  logic              active,
  input  logic [REG_W-1:0]  wdata,
  output logic [LANES-1:0]  be,
  output logic [REG_W-1:0]  lanes
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lane_src_t src;
    assign src   = lane_source(sz, off, big, 2'(k));
    assign be[k] = active & src.hit;
    assign lanes[k*8 +: 8] = be[k] ? wdata[{src.idx, 3'b000} +: 8] : 8'h00;
  end
endmodule

// File: rtl/els_load_steer.sv
module els_load_steer
  import els_pkg::*;
(
  input  size_e             sz,
  input  logic [1:0]        off,
  input  logic              big,
  input  logic              sgn,
  input  logic              active,
  input  logic [REG_W-1:0]  rdata,
  output logic [REG_W-1:0]  value
);
  logic [REG_W-1:0] gathered;

  always_comb begin
    lane_src_t src;
    gathered = '0;
    for (int k = 0; k < LANES; k++) begin
      src = lane_source(sz, off, big, 2'(k));
      if (src.hit) gathered[{src.idx, 3'b000} +: 8] = rdata[k*8 +: 8];
    end
  end

  assign value = active ? extend(sz, sgn, gathered) : '0;
endmodule

// File: rtl/endian_lane_steer.sv
module endian_lane_steer
  import els_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hFF00_0000,
  parameter logic [ADDR_W-1:0] WIN_MASK = 32'hFF00_0000
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              endian_strap,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [31:0]       bus_rdata,
  output logic [3:0]        bus_be,
  output logic              bus_we,
  output logic [31:0]       bus_wdata,
  output logic [31:0]       load_data,
  output logic              req_error
);
  size_e      sz;
  logic [1:0] off;
  logic       little_q;
  logic       win_hit;
  logic       big_eff;
  logic       active;

  assign sz  = size_e'(req_size);
  assign off = req_addr[1:0];

  els_mode_latch u_mode (
    .clk(clk), .por_n(por_n), .strap(endian_strap), .little_o(little_q)
  );

  els_region_decode #(.ADDR_W(ADDR_W), .BASE(WIN_BASE), .MASK(WIN_MASK)) u_win (
    .addr(req_addr), .hit(win_hit)
  );

  // Device-register window overrides the strapped ordering (R6)
  assign big_eff   = ~little_q | win_hit;
  assign req_error = req_valid & misaligned(sz, off);
  assign active    = req_valid & ~req_error;
  assign bus_we    = active & req_write;

  els_store_steer u_st (
    .sz(sz), .off(off), .big(big_eff), .active(active),
    .wdata(req_wdata), .be(bus_be), .lanes(bus_wdata)
  );

  els_load_steer u_ld (
    .sz(sz), .off(off), .big(big_eff), .sgn(req_signed),
    .active(active & ~req_write), .rdata(bus_rdata), .value(load_data)
  );

  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!por_n)
    req_error |-> (bus_be == 4'b0000) && !bus_we && (bus_wdata == 32'h0));

  assert_byte_one_lane_R5: assert property (@(posedge clk) disable iff (!por_n)
    (req_valid && req_size == 2'd0) |-> ($countones(bus_be) == 1) && !req_error);

  assert_window_big_R6: assert property (@(posedge clk) disable iff (!por_n)
    (bus_we && win_hit && req_size == 2'd2) |-> bus_wdata[7:0] == req_wdata[31:24]);

  assert_sign_fill_R8: assert property (@(posedge clk) disable iff (!por_n)
    (active && !req_write && req_signed && req_size == 2'd0)
      |-> load_data[31:8] == {24{load_data[7]}});

  assert_word_two_lanes_R9: assert property (@(posedge clk) disable iff (!por_n)
    (active && req_size == 2'd1) |-> $countones(bus_be) == 2);

endmodule

// File: tb/test_endian_lane_steer.sv
module test_endian_lane_steer;
  localparam logic [31:0] WBASE = 32'hFF00_0000;
  localparam logic [31:0] WMASK = 32'hFF00_0000;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic endian_strap = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0;
  logic [1:0] req_size = 2'd0;
  logic [31:0] req_addr = '0, req_wdata = '0, bus_rdata = '0;
  logic [3:0] bus_be;
  logic bus_we, req_error;
  logic [31:0] bus_wdata, load_data;

  int checks = 0;
  int errors = 0;
  bit model_little = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  endian_lane_steer i_endian_lane_steer (
    .clk(clk), .por_n(por_n), .endian_strap(endian_strap),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_signed(req_signed), .req_addr(req_addr), .req_wdata(req_wdata),
    .bus_rdata(bus_rdata), .bus_be(bus_be), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .load_data(load_data), .req_error(req_error)
  );

  typedef struct {
    string       tag;
    logic [3:0]  be;
    logic        we;
    logic        err;
    logic [31:0] wd;
    logic [31:0] ld;
  } exp_t;

  exp_t exp_q[$];
  event mon_ev;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Independent model: walk bytes by address, then map address offset to lane.
  task automatic do_req(string tag, bit v, bit wr, logic [1:0] sz, bit sgn,
                        logic [31:0] a, logic [31:0] wd, logic [31:0] rd);
    exp_t e;
    int n;
    bit bad, big;
    logic [31:0] raw;
    @(negedge clk);
    req_valid = v; req_write = wr; req_size = sz; req_signed = sgn;
    req_addr = a; req_wdata = wd; bus_rdata = rd;
    n   = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    bad = (sz == 2'd3) || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 2'd0);
    big = !model_little || ((a & WMASK) == WBASE);
    e.tag = tag; e.be = '0; e.we = 1'b0; e.err = v && bad; e.wd = '0; e.ld = '0;
    raw = '0;
    if (v && !bad) begin
      for (int i = 0; i < n; i++) begin
        int lane = int'(a[1:0]) + i;
        int rb   = big ? (n - 1 - i) : i;
        e.be[lane] = 1'b1;
        if (wr) e.wd[lane*8 +: 8] = wd[rb*8 +: 8];
        raw[rb*8 +: 8] = rd[lane*8 +: 8];
      end
      e.we = wr;
      if (!wr) begin
        if (n == 1) e.ld = {(sgn && raw[7]) ? 24'hFFFFFF : 24'h0, raw[7:0]};
        else if (n == 2) e.ld = {(sgn && raw[15]) ? 16'hFFFF : 16'h0, raw[15:0]};
        else e.ld = raw;
      end
    end
    exp_q.push_back(e);
    -> mon_ev;
  endtask

  // Monitor: outputs are combinational (R10), so sample 1 ns after the drive.
  initial begin
    forever begin
      exp_t e;
      @(mon_ev);
      #1;
      e = exp_q.pop_front();
      check({e.tag, " be"},   {28'h0, bus_be},   {28'h0, e.be});
      check({e.tag, " we"},   {31'h0, bus_we},   {31'h0, e.we});
      check({e.tag, " err"},  {31'h0, req_error}, {31'h0, e.err});
      check({e.tag, " wd"},   bus_wdata, e.wd);
      check({e.tag, " ld"},   load_data, e.ld);
    end
  end

  task automatic power_on(bit strap);
    @(negedge clk);
    por_n = 1'b0; endian_strap = strap; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset be", {28'h0, bus_be}, 32'h0);
    check("R1 reset we/err", {30'h0, bus_we, req_error}, 32'h0);
    por_n = 1'b1;
    model_little = strap;
    @(negedge clk);
  endtask

  initial begin
    power_on(1'b0);
    do_req("R10 idle",            0, 1, 2'd2, 0, 32'h100, 32'h11223344, 0);
    do_req("R4 long store big",   1, 1, 2'd2, 0, 32'h100, 32'hA1B2C3D4, 0);
    do_req("R4 word store big +2",1, 1, 2'd1, 0, 32'h102, 32'h0000BEEF, 0);
    do_req("R4 word store big +0",1, 1, 2'd1, 0, 32'h100, 32'h1234CAFE, 0);
    for (int k = 0; k < 4; k++)
      do_req("R5 byte store",     1, 1, 2'd0, 0, 32'h200 + k, 32'hFFFFFF5A, 0);
    do_req("R7 word misaligned",  1, 1, 2'd1, 0, 32'h101, 32'h12345678, 0);
    do_req("R7 long misaligned",  1, 1, 2'd2, 0, 32'h102, 32'h12345678, 0);
    do_req("R7 reserved size",    1, 0, 2'd3, 0, 32'h100, 0, 32'hFFFFFFFF);
    do_req("R8 byte load signed", 1, 0, 2'd0, 1, 32'h301, 0, 32'h0000_8000);
    do_req("R8 byte load zero",   1, 0, 2'd0, 0, 32'h301, 0, 32'h0000_8000);
    do_req("R8 word load signed big", 1, 0, 2'd1, 1, 32'h300, 0, 32'h0000_0080);
    do_req("R9 long load big",    1, 0, 2'd2, 0, 32'h300, 0, 32'h44332211);
    @(negedge clk); endian_strap = 1'b1;
    repeat (2) @(negedge clk);
    do_req("R2 strap ignored",    1, 1, 2'd2, 0, 32'h400, 32'h01020304, 0);

    power_on(1'b1);
    do_req("R1 R3 long store little", 1, 1, 2'd2, 0, 32'h100, 32'hA1B2C3D4, 0);
    do_req("R3 word store little +2", 1, 1, 2'd1, 0, 32'h102, 32'h0000BEEF, 0);
    do_req("R3 word store little +0", 1, 1, 2'd1, 0, 32'h100, 32'h0000BEEF, 0);
    do_req("R5 byte store little",    1, 1, 2'd0, 0, 32'h103, 32'h000000C3, 0);
    do_req("R6 long store window",    1, 1, 2'd2, 0, 32'hFF00_0010, 32'hA1B2C3D4, 0);
    do_req("R6 word store window",    1, 1, 2'd1, 0, 32'hFF00_0012, 32'h0000BEEF, 0);
    do_req("R6 R9 load window",       1, 0, 2'd2, 0, 32'hFF00_0010, 0, 32'h44332211);
    do_req("R9 long load little",     1, 0, 2'd2, 0, 32'h300, 0, 32'h44332211);
    do_req("R9 word load little sgn", 1, 0, 2'd1, 1, 32'h302, 0, 32'h9ABC0000);
    do_req("R8 word load zero",       1, 0, 2'd1, 0, 32'h302, 0, 32'h9ABC0000);
    do_req("R6 R7 window misaligned", 1, 1, 2'd2, 0, 32'hFF00_0011, 32'h12345678, 0);
    do_req("R6 R7 window load misal", 1, 0, 2'd1, 1, 32'hFF00_0013, 0, 32'hFFFFFFFF);
    do_req("R6 below window",         1, 1, 2'd2, 0, 32'hFE00_0010, 32'hA1B2C3D4, 0);
    @(negedge clk); endian_strap = 1'b0;
    repeat (2) @(negedge clk);
    do_req("R2 strap ignored little", 1, 1, 2'd2, 0, 32'h400, 32'h01020304, 0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule